// File: doc/BRIEF.md
# Arithmetic Error Trap Detector

This block sits beside the execution datapath of a DSP-style core that has two 40-bit accumulators (each with eight guard bits above a 32-bit body), a divider and a barrel shifter. It watches the values and control strobes that those units produce. When an operation is illegal or overflows in a way the current mode settings call an error, it raises a math-error trap request toward the core's exception logic.

Four conditions are watched:

- a divide started with a zero divisor;
- an accumulator write-back that no longer fits in 32 bits, meaning it has spilled into the guard bits;
- an accumulator result whose sign is wrong for its operands, meaning it has overflowed the full 40 bits;
- a shift whose signed amount lies outside the legal range.

A divide by zero also produces a one-cycle abort pulse for the divider. A small status vector keeps a sticky flag for each condition, plus the identity of the accumulator that last overflowed. Software clears these flags by writing ones.

All outputs are registered. An event presented on the inputs at one rising edge is visible on `trap_req`, `div_abort` and `status` from that edge on. The accumulator arithmetic and the saturation logic themselves live elsewhere. This block only receives their result and their mode bits.

Top module: `math_trap_unit`

## Requirements
- R1: When `div_start` is high and `div_divisor` is zero at a clock edge, `div_abort` is high for exactly the following cycle, status bit 0 is set and `trap_req` rises. This check has no enable. A divide with a nonzero divisor produces no abort and no flag.
- R2: With `ovf31_en` high, an accumulator write (`acc_wr_en`) whose `acc_result` bits 39:31 are not all equal sets status bit 1 and raises `trap_req`. Results whose bits 39:31 are all zeros or all ones set nothing.
- R3: With `ovf31_en` low, no accumulator write sets status bit 1.
- R4: With `ovf39_en` high and both bits of `sat_en` low, an accumulator write sets status bit 2 and raises `trap_req` when the two operand signs `opnd_a_sign` and `opnd_b_sign` are equal and `acc_result` bit 39 differs from them.
- R5: If either bit of `sat_en` is high, no accumulator write sets status bit 2.
- R6: A `shift_valid` cycle whose signed 6-bit `shift_amt` lies outside -16..+16 sets status bit 3 and raises `trap_req`. Amounts of +16 and -16 are legal.
- R7: Both accumulators are checked under the same rules; `acc_sel` is 0 for A and 1 for B. Whenever an accumulator flag (bit 1 or bit 2) is set, status bit 4 takes the value of `acc_sel` for that write.
- R8: Once raised, `trap_req` stays high until a cycle with `trap_ack` high. If a new event arrives in the same cycle as the acknowledge, `trap_req` stays high.
- R9: Status flags are sticky. A cycle with `stat_clr_wr` high clears each status bit whose `stat_clr_mask` bit is 1. A flag set by an event in that same cycle stays set.
- R10: After reset, `trap_req`, `div_abort` and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_wr_en | input | 1 | Accumulator write-back valid |
| acc_sel | input | 1 | Accumulator written: 0 = A, 1 = B |
| acc_result | input | 40 | Accumulator write-back value |
| opnd_a_sign | input | 1 | Sign bit of the first operand |
| opnd_b_sign | input | 1 | Sign bit of the effective second operand |
| div_start | input | 1 | Divide start strobe |
| div_divisor | input | 16 | Divisor of the starting divide |
| shift_valid | input | 1 | Shift operation valid |
| shift_amt | input | 6 | Signed shift amount |
| ovf31_en | input | 1 | Enable trap on overflow into the guard bits |
| ovf39_en | input | 1 | Enable trap on overflow out of bit 39 |
| sat_en | input | 2 | Saturation enable per accumulator (bit 0 = A, bit 1 = B) |
| trap_ack | input | 1 | Trap acknowledge from the exception logic |
| stat_clr_wr | input | 1 | Write-one-to-clear strobe for the status flags |
| stat_clr_mask | input | 5 | Bits of status to clear |
| trap_req | output | 1 | Registered math-error trap request |
| div_abort | output | 1 | One-cycle abort pulse to the divider |
| status | output | 5 | {acc id, shift, ovf39, ovf31, div-zero} |

## Verification
The accumulator check is driven with three kinds of result: values that spill into the guard bits, values whose upper nine bits are all zeros, and values whose upper nine bits are all ones. Together these separate a true 32-bit overflow from sign extension in both directions. The full-width overflow is tried with matching operand signs and a flipped result sign, then repeated with each saturation bit on. This shows that the suppression needs all saturation off.

The shift range is probed at +16 and -16 (accepted) and at +17 and -17 (trapped), which pins down both edges of the signed range. Divides are tried with zero and nonzero divisors. Acknowledge and clear are tested alone and in collision with a new event, to show which one wins.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
    localparam int ST_W      = 5;
    localparam int ST_DZ     = 0;
    localparam int ST_OV31   = 1;
    localparam int ST_OV39   = 2;
    localparam int ST_SHF    = 3;
    localparam int ST_ACC    = 4;

    typedef struct packed {
        logic            trap;
        logic            abort;
        logic [ST_W-1:0] stat;
    } mtrap_state_t;
endpackage

// File: rtl/mtrap_acc_ovf.sv
module mtrap_acc_ovf #(
    parameter int ACC_W = 40,
    parameter int LOW_W = 32
) (
    input  logic             valid,
    input  logic [ACC_W-1:0] result,
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic             low_en,
    input  logic             high_en,
    input  logic             sat_any,
    output logic             ovf_low,
    output logic             ovf_high
);
    localparam int TOP_N = ACC_W - LOW_W + 1;

    logic [TOP_N-1:0] top_bits;
    logic             top_same;
    logic             sign_flip;

    always_comb begin
        top_bits  = result[ACC_W-1:LOW_W-1];
        top_same  = (&top_bits) | ~(|top_bits);
        sign_flip = (sign_a == sign_b) && (result[ACC_W-1] != sign_a);
        ovf_low   = valid && low_en && !top_same;
        ovf_high  = valid && high_en && !sat_any && sign_flip;
    end
endmodule

// File: rtl/mtrap_div_chk.sv
module mtrap_div_chk #(
    parameter int DIV_W = 16
) (
    input  logic             start,
    input  logic [DIV_W-1:0] divisor,
    output logic             zero_div
);
    always_comb begin
        zero_div = start && (divisor == '0);
    end
endmodule

// File: rtl/mtrap_shift_chk.sv
module mtrap_shift_chk #(
    parameter int SHAMT_W   = 6,
    parameter int SHIFT_MAX = 16
) (
    input  logic               valid,
    input  logic [SHAMT_W-1:0] amt,
    output logic               bad_shift
);
    localparam logic signed [SHAMT_W-1:0] HI_LIM = SHIFT_MAX[SHAMT_W-1:0];
    localparam logic signed [SHAMT_W-1:0] LO_LIM = -HI_LIM;

    logic signed [SHAMT_W-1:0] amt_s;

    always_comb begin
        amt_s     = amt;
        bad_shift = valid && ((amt_s > HI_LIM) || (amt_s < LO_LIM));
    end
endmodule

// File: rtl/math_trap_unit.sv
module math_trap_unit
    import mtrap_pkg::*;
#(
    parameter int ACC_W     = 40,
    parameter int LOW_W     = 32,
    parameter int DIV_W     = 16,
    parameter int SHAMT_W   = 6,
    parameter int SHIFT_MAX = 16,
    parameter int NUM_ACC   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_wr_en,
    input  logic               acc_sel,
    input  logic [ACC_W-1:0]   acc_result,
    input  logic               opnd_a_sign,
    input  logic               opnd_b_sign,
    input  logic               div_start,
    input  logic [DIV_W-1:0]   div_divisor,
    input  logic               shift_valid,
    input  logic [SHAMT_W-1:0] shift_amt,
    input  logic               ovf31_en,
    input  logic               ovf39_en,
    input  logic [NUM_ACC-1:0] sat_en,
    input  logic               trap_ack,
    input  logic               stat_clr_wr,
    input  logic [ST_W-1:0]    stat_clr_mask,
    output logic               trap_req,
    output logic               div_abort,
    output logic [ST_W-1:0]    status
);
    logic [NUM_ACC-1:0] low_hit;
    logic [NUM_ACC-1:0] high_hit;
    logic               sat_any;
    logic               dz_hit;
    logic               shf_hit;

    assign sat_any = |sat_en;

    for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_acc
        logic sel_me;
        assign sel_me = acc_wr_en && (acc_sel == gi[0]);
        mtrap_acc_ovf #(.ACC_W(ACC_W), .LOW_W(LOW_W)) u_ovf (
            .valid    (sel_me),
            .result   (acc_result),
            .sign_a   (opnd_a_sign),
            .sign_b   (opnd_b_sign),
            .low_en   (ovf31_en),
            .high_en  (ovf39_en),
            .sat_any  (sat_any),
            .ovf_low  (low_hit[gi]),
            .ovf_high (high_hit[gi])
        );
    end

    mtrap_div_chk #(.DIV_W(DIV_W)) u_div (
        .start    (div_start),
        .divisor  (div_divisor),
        .zero_div (dz_hit)
    );

    mtrap_shift_chk #(.SHAMT_W(SHAMT_W), .SHIFT_MAX(SHIFT_MAX)) u_shf (
        .valid     (shift_valid),
        .amt       (shift_amt),
        .bad_shift (shf_hit)
    );

    mtrap_state_t st_d, st_q;
    logic [ST_W-1:0] set_bits;
    logic [ST_W-1:0] clr_bits;
    logic            acc_evt;
    logic            any_evt;

    always_comb begin
        acc_evt  = (|low_hit) || (|high_hit);
        any_evt  = acc_evt || dz_hit || shf_hit;
        set_bits = '0;
        set_bits[ST_DZ]   = dz_hit;
        set_bits[ST_OV31] = |low_hit;
        set_bits[ST_OV39] = |high_hit;
        set_bits[ST_SHF]  = shf_hit;
        clr_bits = stat_clr_wr ? stat_clr_mask : '0;

        st_d       = st_q;
        st_d.abort = dz_hit;
        st_d.stat  = (st_q.stat & ~clr_bits) | set_bits;
        if (acc_evt) begin
            st_d.stat[ST_ACC] = acc_sel;
        end
        if (any_evt) begin
            st_d.trap = 1'b1;
        end else if (trap_ack) begin
            st_d.trap = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trap_req  = st_q.trap;
    assign div_abort = st_q.abort;
    assign status    = st_q.stat;
endmodule

// File: rtl/mtrap_checker.sv
module mtrap_checker
    import mtrap_pkg::*;
#(
    parameter int ACC_W     = 40,
    parameter int DIV_W     = 16,
    parameter int SHAMT_W   = 6,
    parameter int NUM_ACC   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               div_start,
    input logic [DIV_W-1:0]   div_divisor,
    input logic               shift_valid,
    input logic [SHAMT_W-1:0] shift_amt,
    input logic               ovf31_en,
    input logic [NUM_ACC-1:0] sat_en,
    input logic               trap_ack,
    input logic               stat_clr_wr,
    input logic [ST_W-1:0]    stat_clr_mask,
    input logic               trap_req,
    input logic               div_abort,
    input logic [ST_W-1:0]    status
);
    logic signed [SHAMT_W-1:0] amt_s;
    assign amt_s = shift_amt;

    p_zero_div_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (div_start && div_divisor == '0) |=> (div_abort && trap_req && status[ST_DZ]));

    p_abort_only_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(div_start && div_divisor == '0) |=> !div_abort);

    p_no_ovf31_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf31_en && !status[ST_OV31]) |=> !status[ST_OV31]);

    p_sat_blocks_ovf39_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sat_en) && !status[ST_OV39]) |=> !status[ST_OV39]);

    p_shift_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_valid && (amt_s > 6'sd16 || amt_s < -6'sd16)) |=> (status[ST_SHF] && trap_req));

    p_trap_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_ack) |=> trap_req);

    p_dz_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_DZ] && !(stat_clr_wr && stat_clr_mask[ST_DZ])) |=> status[ST_DZ]);

    p_shf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_SHF] && !(stat_clr_wr && stat_clr_mask[ST_SHF])) |=> status[ST_SHF]);
endmodule

bind math_trap_unit mtrap_checker #(
    .ACC_W(ACC_W), .DIV_W(DIV_W), .SHAMT_W(SHAMT_W), .NUM_ACC(NUM_ACC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .div_start(div_start), .div_divisor(div_divisor),
    .shift_valid(shift_valid), .shift_amt(shift_amt), .ovf31_en(ovf31_en),
    .sat_en(sat_en), .trap_ack(trap_ack), .stat_clr_wr(stat_clr_wr),
    .stat_clr_mask(stat_clr_mask), .trap_req(trap_req), .div_abort(div_abort),
    .status(status)
);

// File: tb/sim_math_trap_unit.sv
`timescale 1ns/1ps
module sim_math_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr_en = 0, acc_sel = 0, opnd_a_sign = 0, opnd_b_sign = 0;
    logic [39:0] acc_result = '0;
    logic        div_start = 0;
    logic [15:0] div_divisor = '0;
    logic        shift_valid = 0;
    logic [5:0]  shift_amt = '0;
    logic        ovf31_en = 0, ovf39_en = 0;
    logic [1:0]  sat_en = '0;
    logic        trap_ack = 0, stat_clr_wr = 0;
    logic [4:0]  stat_clr_mask = '0;
    logic        trap_req, div_abort;
    logic [4:0]  status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    math_trap_unit u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_wr_en = 0; div_start = 0; shift_valid = 0;
        trap_ack = 0; stat_clr_wr = 0; stat_clr_mask = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        idle(); trap_ack = 1; stat_clr_wr = 1; stat_clr_mask = 5'h1F;
        step(); idle(); step();
    endtask

    task automatic acc_write(input logic sel, input logic [39:0] v, input logic sa, input logic sb);
        idle(); acc_wr_en = 1; acc_sel = sel; acc_result = v;
        opnd_a_sign = sa; opnd_b_sign = sb;
        step(); idle();
    endtask

    task automatic t_reset();
        check("R10 trap_req", trap_req, 0);
        check("R10 div_abort", div_abort, 0);
        check("R10 status", status, 0);
    endtask

    task automatic t_div();
        idle(); div_start = 1; div_divisor = 16'd7; step(); idle();
        check("R1 nonzero abort", div_abort, 0);
        check("R1 nonzero status", status, 0);
        div_start = 1; div_divisor = 16'd0; step(); idle();
        check("R1 abort", div_abort, 1);
        check("R1 status dz", status, 5'b00001);
        check("R1 trap", trap_req, 1);
        step();
        check("R1 abort one cycle", div_abort, 0);
        clear_all();
    endtask

    task automatic t_ovf31();
        ovf31_en = 1; ovf39_en = 0;
        acc_write(0, 40'h00_7FFF_FFFF, 0, 0);
        check("R2 positive fits", status, 0);
        acc_write(0, 40'hFF_8000_0000, 1, 1);
        check("R2 negative fits", status, 0);
        check("R2 no trap", trap_req, 0);
        acc_write(0, 40'h00_8000_0000, 0, 0);
        check("R2 spill status", status, 5'b00010);
        check("R2 spill trap", trap_req, 1);
        clear_all();
        ovf31_en = 0;
        acc_write(0, 40'h01_0000_0000, 0, 0);
        check("R3 disabled status", status, 0);
        check("R3 disabled trap", trap_req, 0);
    endtask

    task automatic t_ovf39();
        ovf31_en = 0; ovf39_en = 1; sat_en = 2'b00;
        acc_write(0, 40'h80_0000_0000, 0, 1);
        check("R4 mixed signs", status, 0);
        acc_write(0, 40'h80_0000_0000, 0, 0);
        check("R4 pos overflow", status, 5'b00100);
        check("R4 trap", trap_req, 1);
        clear_all();
        acc_write(0, 40'h7F_0000_0000, 1, 1);
        check("R4 neg overflow", status, 5'b00100);
        clear_all();
        sat_en = 2'b01;
        acc_write(0, 40'h80_0000_0000, 0, 0);
        check("R5 sat A on", status, 0);
        sat_en = 2'b10;
        acc_write(0, 40'h80_0000_0000, 0, 0);
        check("R5 sat B on", status, 0);
        check("R5 no trap", trap_req, 0);
        sat_en = 2'b00; ovf39_en = 0;
    endtask

    task automatic t_shift();
        idle(); shift_valid = 1; shift_amt = 6'd16; step(); idle();
        check("R6 +16 legal", status, 0);
        shift_valid = 1; shift_amt = 6'b110000; step(); idle();
        check("R6 -16 legal", status, 0);
        shift_valid = 1; shift_amt = 6'd17; step(); idle();
        check("R6 +17 trap", status, 5'b01000);
        check("R6 +17 trap_req", trap_req, 1);
        clear_all();
        shift_valid = 1; shift_amt = 6'b101111; step(); idle();
        check("R6 -17 trap", status, 5'b01000);
        clear_all();
    endtask

    task automatic t_accsel();
        ovf31_en = 1;
        acc_write(1, 40'h02_0000_0000, 0, 0);
        check("R7 acc B flagged", status, 5'b10010);
        acc_write(0, 40'h02_0000_0000, 0, 0);
        check("R7 acc A flagged", status, 5'b00010);
        ovf31_en = 0;
        clear_all();
    endtask

    task automatic t_ack();
        idle(); div_start = 1; div_divisor = 0; step(); idle();
        step(); step();
        check("R8 held", trap_req, 1);
        trap_ack = 1; step(); idle();
        check("R8 ack clears", trap_req, 0);
        check("R9 flag survives ack", status, 5'b00001);
        trap_ack = 1; shift_valid = 1; shift_amt = 6'd20; step(); idle();
        check("R8 event beats ack", trap_req, 1);
        clear_all();
    endtask

    task automatic t_w1c();
        idle(); div_start = 1; div_divisor = 0; step(); idle();
        shift_valid = 1; shift_amt = 6'd30; step(); idle();
        check("R9 both flags", status, 5'b01001);
        stat_clr_wr = 1; stat_clr_mask = 5'b00001; step(); idle();
        check("R9 partial clear", status, 5'b01000);
        stat_clr_wr = 1; stat_clr_mask = 5'b01000;
        shift_valid = 1; shift_amt = 6'd31; step(); idle();
        check("R9 set beats clear", status, 5'b01000);
        clear_all();
        check("R9 all cleared", status, 0);
    endtask

    initial begin
        fork
            begin
                step(); step();
                t_reset();
                rst_n = 1; step();
                t_reset();
                t_div();
                t_ovf31();
                t_ovf39();
                t_shift();
                t_accsel();
                t_ack();
                t_w1c();
                done = 1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog expired");
                end
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule